// File: doc/BRIEF.md
# Page-Mode Flash Read Controller

This block sits on the host side of an asynchronous parallel NOR flash and turns single-word read requests from a synchronous interface into chip-select, output-gate and address activity on the flash pins. The host presents a word address with a valid strobe. When the block is ready, it accepts the request, drives the address, and selects the part with the output gate open. It then waits a programmable number of clock cycles, samples the 16-bit data bus and returns the word with a one-cycle valid pulse.

The flash is organised in pages of eight words. The block remembers which page it last addressed while chip-select stayed low. A later read to that page only needs the short page wait. Any other read needs the long initial wait: the first read after selection, a read to another page, or a read after chip-select was dropped. After a programmable number of cycles with no request, the block releases chip-select, and this also forgets the open page. The write strobe is never pulsed. Every word that comes back is passed through unchanged, including the status words that some sectors return in place of array data.

Top module: `pflash_rd_ctrl`

## Requirements
- R1: The upper address bits `req_addr[ADDR_W-1:3]` select the page and `req_addr[2:0]`, read as 0 to 7, select the word within it. `fl_addr` carries the full accepted request address unchanged.
- R2: Each accepted read produces exactly one `rsp_valid` pulse, one cycle wide. `rsp_data` then holds the value on `fl_dq_in` at the final wait cycle.
- R3: A read that does not hit the open page returns `rsp_valid` exactly `cfg_init_wait` rising edges after the accepting edge. This covers the first read after chip-select goes low and any read to a different page.
- R4: A read whose page matches the open page, with `fl_ce_n` still low, returns after exactly `cfg_page_wait` rising edges.
- R5: When `fl_ce_n` goes high, the open page is forgotten, so the next read takes the initial wait even if it is to the same page.
- R6: While a read is in flight, `fl_ce_n`=0, `fl_oe_n`=0 and `fl_we_n`=1. `fl_oe_n` is never low while `fl_ce_n` is high, and `fl_we_n` stays high at all times.
- R7: With `cfg_idle_limit`=L, where L is not 0, `fl_ce_n` rises on the L-th consecutive rising edge with no read in flight and no request accepted. L=0 keeps chip-select low indefinitely. While idle with the part selected, `fl_oe_n` is high.
- R8: `req_ready` is low while a read is in flight and high otherwise, including in the `rsp_valid` cycle, so a request may be accepted back to back. `fl_addr` holds still for the whole read.
- R9: A programmed wait of 0, initial or page, acts as a wait of 1 cycle.
- R10: Whatever word the flash returns, status words included, appears unchanged on `rsp_data`.
- R11: During and just after synchronous reset, `fl_ce_n`, `fl_oe_n` and `fl_we_n` are 1, `rsp_valid` is 0, `req_ready` is 1 and no page is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request strobe |
| req_addr | input | ADDR_W | Word address of the read |
| req_ready | output | 1 | Request can be accepted this cycle |
| cfg_init_wait | input | WAIT_W | Cycles for an initial (page-miss) access |
| cfg_page_wait | input | WAIT_W | Cycles for a page-hit access |
| cfg_idle_limit | input | IDLE_W | Idle cycles before chip-select is released, 0 = never |
| rsp_valid | output | 1 | One-cycle pulse: read data valid |
| rsp_data | output | DATA_W | Returned word |
| fl_ce_n | output | 1 | Flash chip select, active low |
| fl_oe_n | output | 1 | Flash output gate, active low |
| fl_we_n | output | 1 | Flash write strobe, held high |
| fl_addr | output | ADDR_W | Flash word address |
| fl_dq_in | input | DATA_W | Flash data bus |

## Verification
A wrongly set open-page record shows up as a latency error on the very next read. A stale hit returns after the page wait where the initial wait was due, and a missed hit costs the initial wait. Both are visible within one access at `rsp_valid`. Idle-counter faults show up as `fl_ce_n` rising one or more cycles early, late or never, and so as a wrong latency on the following same-page read. A sampling or hand-off fault shows up as wrong `rsp_data`, or as a second or missing `rsp_valid` pulse, in the cycle the read completes.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

    // Three low address bits pick the word inside an 8-word page.
    localparam int unsigned WORD_IDX_W = 3;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,   // chip deselected, no page open
        ST_OPEN = 2'd1,   // chip selected, waiting for a request
        ST_READ = 2'd2    // access in flight
    } rd_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
    } strobe_t;

    localparam strobe_t STROBE_OFF  = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1};
    localparam strobe_t STROBE_READ = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1};
    localparam strobe_t STROBE_HOLD = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1};

endpackage

// File: rtl/pflash_wait_timer.sv
module pflash_wait_timer #(
    parameter int unsigned WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    output logic              busy,
    output logic              done
);

    logic [WAIT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == WAIT_W'(1));

    // R9: the controller never starts an access with a zero count
    p_load_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
        load |-> (load_val != '0));

    // R8: a new access is never loaded over one in flight
    p_load_when_free_r8: assert property (@(posedge clk) disable iff (rst)
        load |-> !busy);

endmodule

// File: rtl/pflash_idle_timer.sv
module pflash_idle_timer #(
    parameter int unsigned IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic [IDLE_W-1:0] limit,
    output logic              expire
);

    logic [IDLE_W-1:0] cnt_q;
    logic [IDLE_W:0]   cnt_next;

    assign cnt_next = {1'b0, cnt_q} + 1'b1;
    assign expire   = arm && (limit != '0) && (cnt_next >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst || !arm || expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_next[IDLE_W-1:0];
        end
    end

    // R7: an idle run never expires on its first armed cycle unless the limit is 1
    p_no_early_expire_r7: assert property (@(posedge clk) disable iff (rst)
        (arm && !$past(arm) && limit > IDLE_W'(1)) |-> !expire);

endmodule

// File: rtl/pflash_page_track.sv
module pflash_page_track #(
    parameter int unsigned TAG_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic [TAG_W-1:0] cap_tag,
    input  logic             invalidate,
    input  logic [TAG_W-1:0] query_tag,
    output logic             valid,
    output logic             hit
);

    logic [TAG_W-1:0] tag_q;
    logic             valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q   <= '0;
            valid_q <= 1'b0;
        end else if (capture) begin
            tag_q   <= cap_tag;
            valid_q <= 1'b1;
        end else if (invalidate) begin
            valid_q <= 1'b0;
        end
    end

    assign valid = valid_q;
    assign hit   = valid_q && (tag_q == query_tag);

    // R5: a drop request leaves no page open on the next cycle
    p_drop_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (invalidate && !capture) |=> !valid);

    // R1: a captured page is reported as a hit for the same page next cycle
    p_capture_hits_r1: assert property (@(posedge clk) disable iff (rst)
        capture |=> (valid && (tag_q == $past(cap_tag))));

endmodule

// File: rtl/pflash_rd_ctrl.sv
module pflash_rd_ctrl
    import pflash_pkg::*;
#(
    parameter int unsigned ADDR_W = 23,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned WAIT_W = 4,
    parameter int unsigned IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    input  logic [WAIT_W-1:0] cfg_init_wait,
    input  logic [WAIT_W-1:0] cfg_page_wait,
    input  logic [IDLE_W-1:0] cfg_idle_limit,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              fl_ce_n,
    output logic              fl_oe_n,
    output logic              fl_we_n,
    output logic [ADDR_W-1:0] fl_addr,
    input  logic [DATA_W-1:0] fl_dq_in
);

    localparam int unsigned TAG_W = ADDR_W - WORD_IDX_W;

    rd_state_e         st_q;
    strobe_t           strobe_q;
    logic [ADDR_W-1:0] addr_q;
    logic              rsp_valid_q;
    logic [DATA_W-1:0] rsp_data_q;

    logic              accept;
    logic              page_hit;
    logic              pg_valid;
    logic              pg_match;
    logic [WAIT_W-1:0] wait_sel;
    logic [WAIT_W-1:0] wait_eff;
    logic              tmr_busy;
    logic              tmr_done;
    logic              idle_arm;
    logic              idle_expire;
    logic [TAG_W-1:0]  req_tag;

    assign req_ready = (st_q != ST_READ);
    assign accept    = req_valid && req_ready;
    assign req_tag   = req_addr[ADDR_W-1:WORD_IDX_W];

    // A hit needs the tracked page and the chip still selected.
    assign page_hit  = pg_match && (st_q == ST_OPEN);
    assign wait_sel  = page_hit ? cfg_page_wait : cfg_init_wait;
    assign wait_eff  = (wait_sel == '0) ? WAIT_W'(1) : wait_sel;

    assign idle_arm  = (st_q == ST_OPEN) && !accept;

    pflash_wait_timer #(.WAIT_W(WAIT_W)) u_wait (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (wait_eff),
        .busy     (tmr_busy),
        .done     (tmr_done)
    );

    pflash_idle_timer #(.IDLE_W(IDLE_W)) u_idle (
        .clk    (clk),
        .rst    (rst),
        .arm    (idle_arm),
        .limit  (cfg_idle_limit),
        .expire (idle_expire)
    );

    pflash_page_track #(.TAG_W(TAG_W)) u_page (
        .clk        (clk),
        .rst        (rst),
        .capture    (accept),
        .cap_tag    (req_tag),
        .invalidate (idle_expire),
        .query_tag  (req_tag),
        .valid      (pg_valid),
        .hit        (pg_match)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_OFF;
            strobe_q    <= STROBE_OFF;
            addr_q      <= '0;
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            if (accept) begin
                st_q     <= ST_READ;
                strobe_q <= STROBE_READ;
                addr_q   <= req_addr;
            end else if ((st_q == ST_READ) && tmr_done) begin
                st_q        <= ST_OPEN;
                strobe_q    <= STROBE_HOLD;
                rsp_valid_q <= 1'b1;
                rsp_data_q  <= fl_dq_in;
            end else if (idle_expire) begin
                st_q     <= ST_OFF;
                strobe_q <= STROBE_OFF;
            end
        end
    end

    assign fl_ce_n   = strobe_q.ce_n;
    assign fl_oe_n   = strobe_q.oe_n;
    assign fl_we_n   = strobe_q.we_n;
    assign fl_addr   = addr_q;
    assign rsp_valid = rsp_valid_q;
    assign rsp_data  = rsp_data_q;

    // R6: the output gate only opens while the part is selected
    p_oe_needs_ce_r6: assert property (@(posedge clk) disable iff (rst)
        !fl_oe_n |-> !fl_ce_n);

    // R2: the valid strobe is a single-cycle pulse
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R2: a response only follows a cycle with a read in flight
    p_rsp_after_read_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($past(st_q) == ST_READ));

    // R8: the wait counter runs only during a read
    p_timer_in_read_r8: assert property (@(posedge clk) disable iff (rst)
        tmr_busy |-> (st_q == ST_READ));

    // R8: address held steady across the access
    p_addr_hold_r8: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_READ) && ($past(st_q) == ST_READ)) |-> $stable(fl_addr));

    // R5: deselected part never has a page recorded as open
    p_page_closed_r5: assert property (@(posedge clk) disable iff (rst)
        fl_ce_n |-> !pg_valid);

endmodule

// File: tb/tb_pflash_rd_ctrl.sv
module tb_pflash_rd_ctrl;

    localparam int unsigned ADDR_W = 23;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned WAIT_W = 4;
    localparam int unsigned IDLE_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_ready;
    logic [WAIT_W-1:0] cfg_init_wait = 4'd6;
    logic [WAIT_W-1:0] cfg_page_wait = 4'd2;
    logic [IDLE_W-1:0] cfg_idle_limit = 8'd5;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic              fl_ce_n, fl_oe_n, fl_we_n;
    logic [ADDR_W-1:0] fl_addr;
    logic [DATA_W-1:0] fl_dq_in;

    int n_checks = 0;
    int n_bad    = 0;

    always #5 clk = ~clk;

    // Flash model: sector 7'h5A answers with a fixed status word.
    function automatic logic [DATA_W-1:0] model(input logic [ADDR_W-1:0] a);
        if (a[ADDR_W-1:16] == 7'h5A) return 16'h00C8;
        return a[15:0] ^ 16'h5AA5 ^ {a[22:16], 9'h000};
    endfunction

    assign fl_dq_in = (!fl_ce_n && !fl_oe_n) ? model(fl_addr) : 16'h0000;

    pflash_rd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W), .IDLE_W(IDLE_W)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .cfg_init_wait(cfg_init_wait), .cfg_page_wait(cfg_page_wait), .cfg_idle_limit(cfg_idle_limit),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
        .fl_we_n(fl_we_n), .fl_addr(fl_addr), .fl_dq_in(fl_dq_in)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Issue one read at the current negedge; return at the negedge where rsp_valid is seen.
    task automatic do_read(input logic [ADDR_W-1:0] a, input int exp_lat, input string req);
        int n;
        bit strobe_ok;
        int guard;
        guard = 0;
        while (!req_ready && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        strobe_ok = 1'b1;
        do begin
            if (fl_ce_n !== 1'b0 || fl_oe_n !== 1'b0 || fl_we_n !== 1'b1 || req_ready !== 1'b0
                || fl_addr !== a)
                strobe_ok = 1'b0;
            @(negedge clk);
            n++;
        end while (!rsp_valid && n < 100);
        chk(strobe_ok, "R6/R8 strobes, ready and address during read", {fl_ce_n, fl_oe_n, fl_we_n}, 3'b001);
        chk(n == exp_lat, {req, " latency"}, n, exp_lat);
        chk(rsp_data === model(a), "R2 data returned", rsp_data, model(a));
        chk(req_ready === 1'b1, "R8 ready in response cycle", req_ready, 1);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk({fl_ce_n, fl_oe_n, fl_we_n} === 3'b111, "R11 strobes in reset", {fl_ce_n, fl_oe_n, fl_we_n}, 3'b111);
        chk(rsp_valid === 1'b0, "R11 no response in reset", rsp_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready === 1'b1, "R11 ready after reset", req_ready, 1);
        chk(fl_ce_n === 1'b1, "R11 deselected after reset", fl_ce_n, 1);
    endtask

    task automatic t_first_and_hits();
        // first read after select: initial wait (R3)
        do_read(23'h001230, 6, "R3 first read");
        // every word of the same page, in scrambled order: page wait (R1, R4)
        do_read(23'h001237, 2, "R4 hit word 7");
        do_read(23'h001230, 2, "R4 hit word 0");
        for (int w = 1; w < 7; w++) begin
            do_read({20'h00246, w[2:0]}, 2, "R1 word index hit");
        end
    endtask

    task automatic t_page_miss();
        do_read(23'h001238, 6, "R3 next page miss");
        do_read(23'h001230, 6, "R3 return page miss");
        do_read(23'h7F1230, 6, "R1 upper bits differ miss");
    endtask

    task automatic t_single_pulse();
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R2 pulse one cycle", rsp_valid, 0);
        repeat (2) @(negedge clk);
        chk(rsp_valid === 1'b0, "R2 no extra pulse", rsp_valid, 0);
        chk(fl_oe_n === 1'b1 && fl_ce_n === 1'b0, "R7 gate closed while idle selected",
            {fl_ce_n, fl_oe_n}, 2'b01);
    endtask

    task automatic t_idle_close();
        cfg_idle_limit = 8'd5;
        do_read(23'h003000, 6, "R3 before timeout");
        for (int m = 1; m <= 5; m++) begin
            @(negedge clk);
            if (m == 4) chk(fl_ce_n === 1'b0, "R7 still selected before limit", fl_ce_n, 0);
            if (m == 5) chk(fl_ce_n === 1'b1, "R7 released at limit", fl_ce_n, 1);
        end
        do_read(23'h003001, 6, "R5 same page after release");
    endtask

    task automatic t_no_timeout();
        bit stayed;
        cfg_idle_limit = 8'd0;
        do_read(23'h004400, 6, "R3 before long idle");
        stayed = 1'b1;
        for (int m = 0; m < 40; m++) begin
            @(negedge clk);
            if (fl_ce_n !== 1'b0) stayed = 1'b0;
        end
        chk(stayed, "R7 limit zero keeps select", fl_ce_n, 0);
        do_read(23'h004405, 2, "R4 hit after long idle");
        cfg_idle_limit = 8'd5;
    endtask

    task automatic t_zero_wait();
        cfg_page_wait = 4'd0;
        do_read(23'h005000, 6, "R3 miss with page wait zero");
        do_read(23'h005003, 1, "R9 page wait zero");
        cfg_init_wait = 4'd0;
        do_read(23'h006000, 1, "R9 init wait zero");
        cfg_init_wait = 4'd6;
        cfg_page_wait = 4'd2;
    endtask

    task automatic t_status();
        do_read(23'h5A0010, 6, "R10 status sector miss");
        chk(rsp_data === 16'h00C8, "R10 status word passed", rsp_data, 16'h00C8);
        do_read(23'h5A0014, 2, "R10 status sector hit");
        chk(rsp_data === 16'h00C8, "R10 status word on hit", rsp_data, 16'h00C8);
    endtask

    initial begin
        t_reset();
        @(negedge clk);
        t_first_and_hits();
        t_page_miss();
        t_single_pulse();
        t_idle_close();
        t_no_timeout();
        t_zero_wait();
        t_status();
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule